// File: doc/BRIEF.md
# Dual-Mode 16-bit PWM Timer

This block is a 16-bit timer/counter that produces one pulse-width-modulated output. It runs in one of two families of waveform: a single-slope family, where the counter climbs from zero to a limit and wraps, and a dual-slope family, where the counter climbs to the limit and then descends back to zero. The limit is picked at run time. It is either a fixed 8-, 9- or 10-bit all-ones value, or the content of a period register, or the content of the compare register.

A clock-enable prescaler sets the rate of the timer clock. The compare register decides where the output changes level inside each period. An output-mode field selects normal polarity, inverted polarity, toggle on match, or no drive. Software reaches the block through a simple write port with three registers. The compare and period registers are double-buffered, so a new value only takes effect at a period boundary. A one-cycle flag marks every compare match, and the running count is visible on an output.

Top module: `pwm_timer16`

## Requirements
- R1: While reset is asserted and in the first cycle after it, cnt_out is 0, pwm_out is 0 and match_flag is 0. All registers reset to 0.
- R2: The clock-select field gives one timer tick per 1, 8, 64, 256 or 1024 clocks for codes 1, 2, 3, 4 and 5. Codes 0, 6 and 7 give no ticks, and the count then holds its value.
- R3: Waveform codes 5, 6, 7, 14 and 15 count single-slope from 0 up to TOP and then wrap to 0, for a period of TOP+1 ticks. TOP is 0x00FF, 0x01FF, 0x03FF, the period register or the compare register, in that order. Codes 1, 2 and 3 use the same three fixed TOP values, code 10 uses the period register and code 11 uses the compare register. Any code outside these ten keeps the count at 0.
- R4: Waveform codes 1, 2, 3, 10 and 11 count dual-slope. The count rises from 0 to TOP and then falls back to 0, holding TOP and 0 for exactly one tick each, for a period of 2*TOP ticks.
- R5: In single-slope codes, output mode 2 sets the output at the wrap from TOP and clears it on a compare match. The output is then high for compare+1 ticks of every period. Output mode 3 gives the complement.
- R6: In single-slope codes with output mode 2, a compare value of 0 gives a high spike one tick long in every period. A compare value equal to TOP gives a constant high with mode 2 and a constant low with mode 3.
- R7: In dual-slope codes, output mode 2 clears the output on a match while the count moves upward and sets it on a match while the count moves downward. A match at TOP counts as moving down, and a match at 0 counts as moving up. The output is high for 2*compare ticks per period. Output mode 3 gives the complement.
- R8: Output mode 1 with waveform code 15 toggles the output on every match, giving a period of 2*(TOP+1) ticks at 50% duty. Output mode 1 with any other code, and output mode 0 with any code, drive the output low.
- R9: Writes to the compare and period registers are held in a buffer. In single-slope codes the buffer is copied to the active register at the wrap from TOP. In dual-slope codes the copy happens at the tick where the count is 0. In any other code the copy happens every clock.
- R10: match_flag is high for one clock right after each timer tick at which the count equals the active compare value, and only in the ten waveform codes.
- R11: A register-defined TOP of 3, the smallest legal value, works in both families: it gives a period of 4 ticks single-slope and 6 ticks dual-slope.
- R12: Writes decode wr_addr as follows. Address 0 is control: waveform code in bits 3:0, output mode in bits 5:4, clock select in bits 8:6. Address 1 is the compare register and address 2 is the period register. A write to address 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select for a write |
| wr_data | input | 16 | Write data |
| cnt_out | output | 16 | Current count |
| pwm_out | output | 1 | PWM waveform output |
| match_flag | output | 1 | One-clock pulse after each compare match |

## Verification
On every cycle the assertions check the following: single steps of the count, the turn at TOP and the turn at 0 in dual-slope codes, holding of the count between ticks, holding of the active registers away from their load points, the cause of each match flag, the set at the wrap in normal polarity, and the undriven output mode. Whole-period facts can only be shown by the bench scenarios, which measure them from the output pin. These facts are the measured periods and duty cycles for each family and polarity, the spike, constant-level and toggle corner cases, the real divide ratio of each clock-select code, the minimum TOP, the deferred effect of a mid-period register write, and the ignored address.

// File: rtl/pwm_timer16_pkg.sv
package pwm_timer16_pkg;
  localparam int CNT_W  = 16;
  localparam int MODE_W = 4;
  localparam int OM_W   = 2;
  localparam int CS_W   = 3;
  localparam int DIV_W  = 10;
  localparam int ADDR_W = 2;

  localparam int F_MODE_LSB = 0;
  localparam int F_OM_LSB   = F_MODE_LSB + MODE_W;
  localparam int F_CS_LSB   = F_OM_LSB + OM_W;

  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [MODE_W-1:0] mode_t;
  typedef logic [OM_W-1:0]   om_t;
  typedef logic [CS_W-1:0]   cs_t;

  typedef struct packed {
    mode_t mode;
    om_t   om;
    cs_t   cs;
  } ctrl_t;

  localparam mode_t WG_PC8    = 4'd1;
  localparam mode_t WG_PC9    = 4'd2;
  localparam mode_t WG_PC10   = 4'd3;
  localparam mode_t WG_FS8    = 4'd5;
  localparam mode_t WG_FS9    = 4'd6;
  localparam mode_t WG_FS10   = 4'd7;
  localparam mode_t WG_PC_PER = 4'd10;
  localparam mode_t WG_PC_CMP = 4'd11;
  localparam mode_t WG_FS_PER = 4'd14;
  localparam mode_t WG_FS_CMP = 4'd15;

  localparam om_t OM_OFF    = 2'd0;
  localparam om_t OM_TOGGLE = 2'd1;
  localparam om_t OM_NORMAL = 2'd2;
  localparam om_t OM_INVERT = 2'd3;

  localparam logic [ADDR_W-1:0] RA_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] RA_CMP  = 2'd1;
  localparam logic [ADDR_W-1:0] RA_PER  = 2'd2;

  localparam cnt_t TOP_B8  = cnt_t'((32'd1 << 8) - 32'd1);
  localparam cnt_t TOP_B9  = cnt_t'((32'd1 << 9) - 32'd1);
  localparam cnt_t TOP_B10 = cnt_t'((32'd1 << 10) - 32'd1);

  function automatic logic mode_is_fast(input mode_t m);
    return (m == WG_FS8) || (m == WG_FS9) || (m == WG_FS10) ||
           (m == WG_FS_PER) || (m == WG_FS_CMP);
  endfunction

  function automatic logic mode_is_dual(input mode_t m);
    return (m == WG_PC8) || (m == WG_PC9) || (m == WG_PC10) ||
           (m == WG_PC_PER) || (m == WG_PC_CMP);
  endfunction

  function automatic cnt_t top_of(input mode_t m, input cnt_t cmp, input cnt_t per);
    cnt_t t;
    case (m)
      WG_PC8,    WG_FS8:    t = TOP_B8;
      WG_PC9,    WG_FS9:    t = TOP_B9;
      WG_PC10,   WG_FS10:   t = TOP_B10;
      WG_PC_PER, WG_FS_PER: t = per;
      WG_PC_CMP, WG_FS_CMP: t = cmp;
      default:              t = '0;
    endcase
    return t;
  endfunction

  function automatic logic clk_running(input cs_t sel);
    return (sel >= 3'd1) && (sel <= 3'd5);
  endfunction

  function automatic int clk_shift(input cs_t sel);
    case (sel)
      3'd2:    return 3;
      3'd3:    return 6;
      3'd4:    return 8;
      3'd5:    return 10;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale
  import pwm_timer16_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cs_t  sel,
  output logic tick
);
  logic [DIV_W-1:0] pre_q;
  logic [DIV_W-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  always_comb begin
    mask = DIV_W'((32'd1 << clk_shift(sel)) - 32'd1);
    tick = clk_running(sel) && ((pre_q & mask) == mask);
  end
endmodule

// File: rtl/pwm_reg_bank.sv
module pwm_reg_bank
  import pwm_timer16_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  cnt_t              wr_data,
  input  logic              load_pt,
  output ctrl_t             ctrl_q,
  output cnt_t              cmp_act,
  output cnt_t              per_act
);
  cnt_t cmp_buf, per_buf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      cmp_buf <= '0;
      per_buf <= '0;
      cmp_act <= '0;
      per_act <= '0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          RA_CTRL: begin
            ctrl_q.mode <= wr_data[F_MODE_LSB +: MODE_W];
            ctrl_q.om   <= wr_data[F_OM_LSB +: OM_W];
            ctrl_q.cs   <= wr_data[F_CS_LSB +: CS_W];
          end
          RA_CMP:  cmp_buf <= wr_data;
          RA_PER:  per_buf <= wr_data;
          default: ;
        endcase
      end
      if (load_pt) begin
        cmp_act <= cmp_buf;
        per_act <= per_buf;
      end
    end
  end
endmodule

// File: rtl/pwm_count_core.sv
module pwm_count_core
  import pwm_timer16_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run_fast,
  input  logic run_dual,
  input  cnt_t top_val,
  output cnt_t cnt_q,
  output logic dir_up,
  output logic wrap_ev,
  output logic load_pt,
  output logic moving_up
);
  logic running;
  logic at_bot;
  logic at_or_over_top;

  always_comb begin
    running        = run_fast || run_dual;
    at_bot         = (cnt_q == '0);
    at_or_over_top = (cnt_q >= top_val);
    wrap_ev        = tick && run_fast && at_or_over_top;
    load_pt        = !running || wrap_ev || (tick && run_dual && at_bot);
    moving_up      = dir_up ? !at_or_over_top : at_bot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      dir_up <= 1'b1;
    end else if (!running) begin
      cnt_q  <= '0;
      dir_up <= 1'b1;
    end else if (tick) begin
      if (run_fast) begin
        dir_up <= 1'b1;
        cnt_q  <= at_or_over_top ? '0 : cnt_q + 1'b1;
      end else if (dir_up) begin
        if (!at_or_over_top) begin
          cnt_q <= cnt_q + 1'b1;
        end else if (!at_bot) begin
          cnt_q  <= cnt_q - 1'b1;
          dir_up <= 1'b0;
        end
      end else begin
        if (at_bot) begin
          cnt_q  <= cnt_q + 1'b1;
          dir_up <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pwm_wave_out.sv
module pwm_wave_out
  import pwm_timer16_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  run_fast,
  input  logic  run_dual,
  input  mode_t mode,
  input  om_t   om,
  input  cnt_t  cnt_q,
  input  cnt_t  cmp_act,
  input  logic  wrap_ev,
  input  logic  moving_up,
  output logic  match_ev,
  output logic  pwm_out,
  output logic  match_flag
);
  logic lvl_q, tog_q;

  assign match_ev = tick && (run_fast || run_dual) && (cnt_q == cmp_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q      <= 1'b0;
      tog_q      <= 1'b0;
      match_flag <= 1'b0;
    end else begin
      match_flag <= match_ev;
      if (!(run_fast || run_dual))  lvl_q <= 1'b0;
      else if (run_fast) begin
        if (wrap_ev)                lvl_q <= 1'b1;
        else if (match_ev)          lvl_q <= 1'b0;
      end else if (match_ev)        lvl_q <= !moving_up;
      if (mode != WG_FS_CMP)        tog_q <= 1'b0;
      else if (match_ev)            tog_q <= !tog_q;
    end
  end

  always_comb begin
    case (om)
      OM_NORMAL: pwm_out = lvl_q;
      OM_INVERT: pwm_out = !lvl_q;
      OM_TOGGLE: pwm_out = (mode == WG_FS_CMP) && tog_q;
      default:   pwm_out = 1'b0;
    endcase
  end
endmodule

// File: rtl/pwm_timer16.sv
module pwm_timer16
  import pwm_timer16_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [15:0] wr_data,
  output logic [15:0] cnt_out,
  output logic        pwm_out,
  output logic        match_flag
);
  ctrl_t ctrl_q;
  cnt_t  cmp_act, per_act, cnt_q, top_val;
  logic  tick, run_fast, run_dual;
  logic  dir_up, wrap_ev, load_pt, moving_up, match_ev;

  assign run_fast = mode_is_fast(ctrl_q.mode);
  assign run_dual = mode_is_dual(ctrl_q.mode);
  assign top_val  = top_of(ctrl_q.mode, cmp_act, per_act);
  assign cnt_out  = cnt_q;

  pwm_reg_bank u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .load_pt(load_pt), .ctrl_q(ctrl_q),
    .cmp_act(cmp_act), .per_act(per_act)
  );

  pwm_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .sel(ctrl_q.cs), .tick(tick)
  );

  pwm_count_core u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run_fast(run_fast),
    .run_dual(run_dual), .top_val(top_val), .cnt_q(cnt_q),
    .dir_up(dir_up), .wrap_ev(wrap_ev), .load_pt(load_pt),
    .moving_up(moving_up)
  );

  pwm_wave_out u_wave (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run_fast(run_fast),
    .run_dual(run_dual), .mode(ctrl_q.mode), .om(ctrl_q.om),
    .cnt_q(cnt_q), .cmp_act(cmp_act), .wrap_ev(wrap_ev),
    .moving_up(moving_up), .match_ev(match_ev), .pwm_out(pwm_out),
    .match_flag(match_flag)
  );
endmodule

// File: rtl/pwm_timer16_chk.sv
module pwm_timer16_chk
  import pwm_timer16_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        run_fast,
  input logic        run_dual,
  input cnt_t        cnt_q,
  input cnt_t        top_val,
  input logic        dir_up,
  input logic        load_pt,
  input logic        wrap_ev,
  input cnt_t        cmp_act,
  input cnt_t        per_act,
  input om_t         om,
  input logic        wr_en,
  input logic [1:0]  wr_addr,
  input logic        pwm_out,
  input logic        match_flag
);
  AST_FAST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_fast && tick && cnt_q < top_val) |=> cnt_q == $past(cnt_q) + 1'b1); // R3

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ((run_fast || run_dual) && !tick) |=> $stable(cnt_q)); // R2

  AST_DUAL_TURN_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_dual && tick && dir_up && cnt_q >= top_val && cnt_q != '0)
      |=> (cnt_q == $past(cnt_q) - 1'b1) && !dir_up); // R4

  AST_DUAL_TURN_BOT: assert property (@(posedge clk) disable iff (!rst_n)
    (run_dual && tick && !dir_up && cnt_q == '0) |=> (cnt_q == 16'd1) && dir_up); // R4

  AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((run_fast || run_dual) && !load_pt) |=> $stable(cmp_act) && $stable(per_act)); // R9

  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    match_flag |-> $past(tick) && $past(cnt_q == cmp_act)); // R10

  AST_OUT_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (om == OM_OFF) |-> !pwm_out); // R8

  AST_WRAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_ev && om == OM_NORMAL && !(wr_en && wr_addr == RA_CTRL)) |=> pwm_out); // R5
endmodule

bind pwm_timer16 pwm_timer16_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .run_fast(run_fast),
  .run_dual(run_dual), .cnt_q(cnt_q), .top_val(top_val), .dir_up(dir_up),
  .load_pt(load_pt), .wrap_ev(wrap_ev), .cmp_act(cmp_act),
  .per_act(per_act), .om(ctrl_q.om), .wr_en(wr_en), .wr_addr(wr_addr),
  .pwm_out(pwm_out), .match_flag(match_flag)
);

// File: tb/pwm_timer16_tb_top.sv
module pwm_timer16_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [15:0] cnt_out;
  logic        pwm_out, match_flag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwm_timer16 dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt_out(cnt_out), .pwm_out(pwm_out),
    .match_flag(match_flag)
  );

  // behavioural reference model
  int m_pre, m_cnt, m_up, m_lvl, m_tog, m_flag;
  int m_mode, m_om, m_cs, m_cbuf, m_pbuf, m_cact, m_pact;

  function automatic int m_top(int md, int c, int p);
    if (md == 1 || md == 5) return 255;
    if (md == 2 || md == 6) return 511;
    if (md == 3 || md == 7) return 1023;
    if (md == 10 || md == 14) return p;
    if (md == 11 || md == 15) return c;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_up = 1; m_lvl = 0; m_tog = 0; m_flag = 0;
      m_mode = 0; m_om = 0; m_cs = 0; m_cbuf = 0; m_pbuf = 0; m_cact = 0; m_pact = 0;
    end else begin
      int dv, top;
      bit tk, fs, ds, mt, upn;
      dv = (m_cs == 1) ? 1 : (m_cs == 2) ? 8 : (m_cs == 3) ? 64 :
           (m_cs == 4) ? 256 : (m_cs == 5) ? 1024 : 0;
      tk = (dv != 0) && ((m_pre % dv) == dv - 1);
      fs = (m_mode == 5 || m_mode == 6 || m_mode == 7 || m_mode == 14 || m_mode == 15);
      ds = (m_mode == 1 || m_mode == 2 || m_mode == 3 || m_mode == 10 || m_mode == 11);
      top = m_top(m_mode, m_cact, m_pact);
      mt = tk && (fs || ds) && (m_cnt == m_cact);
      m_flag = mt ? 1 : 0;
      if (m_mode != 15) m_tog = 0;
      else if (mt) m_tog = 1 - m_tog;
      if (!(fs || ds)) begin
        m_cnt = 0; m_up = 1; m_lvl = 0; m_cact = m_cbuf; m_pact = m_pbuf;
      end else if (tk && fs) begin
        if (m_cnt >= top) begin
          m_lvl = 1; m_cnt = 0; m_cact = m_cbuf; m_pact = m_pbuf;
        end else begin
          if (mt) m_lvl = 0;
          m_cnt = m_cnt + 1;
        end
      end else if (tk) begin
        upn = (m_up == 1) ? (m_cnt < top) : (m_cnt == 0);
        if (mt) m_lvl = upn ? 0 : 1;
        if (m_cnt == 0) begin m_cact = m_cbuf; m_pact = m_pbuf; end
        if (upn) begin m_cnt = m_cnt + 1; m_up = 1; end
        else begin m_cnt = m_cnt - 1; m_up = 0; end
      end
      if (wr_en) begin
        if (wr_addr == 0) begin
          m_mode = wr_data[3:0]; m_om = wr_data[5:4]; m_cs = wr_data[8:6];
        end else if (wr_addr == 1) m_cbuf = wr_data;
        else if (wr_addr == 2) m_pbuf = wr_data;
      end
      m_pre = (m_pre + 1) % 1024;
    end
  end

  function automatic bit m_out();
    if (m_om == 2) return m_lvl != 0;
    if (m_om == 3) return m_lvl == 0;
    if (m_om == 1) return (m_mode == 15) && (m_tog != 0);
    return 1'b0;
  endfunction

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model (R3 R4 R5 R7 R10)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check_eq("R3/R4 model count", int'(cnt_out), m_cnt);
      check_eq("R5/R7 model pwm_out", int'(pwm_out), int'(m_out()));
      check_eq("R10 model match_flag", int'(match_flag), m_flag);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setup(input int md, input int om, input int cs, input int cmp, input int per);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    wr(2, per);
    wr(1, cmp);
    wr(0, (cs << 6) | (om << 4) | md);
  endtask

  task automatic measure(output int per, output int hi);
    int guard = 0;
    bit prev;
    per = 0; hi = 0;
    while (pwm_out && guard < 40000) begin @(negedge clk); guard++; end
    while (!pwm_out && guard < 40000) begin @(negedge clk); guard++; end
    per = 1; hi = 1; prev = 1'b1;
    while (guard < 40000) begin
      @(negedge clk); guard++;
      if (pwm_out && !prev) break;
      per++;
      if (pwm_out) hi++;
      prev = pwm_out;
    end
  endtask

  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (pwm_out) hi++; end
  endtask

  task automatic count_flags(input int n, output int f);
    f = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (match_flag) f++; end
  endtask

  task automatic step_gap(output int g);
    logic [15:0] prev;
    int guard = 0;
    @(negedge clk); prev = cnt_out;
    while (cnt_out == prev && guard < 5000) begin @(negedge clk); guard++; end
    prev = cnt_out; g = 0;
    while (guard < 5000) begin
      @(negedge clk); g++; guard++;
      if (cnt_out != prev) break;
    end
  endtask

  task automatic wait_cnt(input int v);
    int guard = 0;
    while (int'(cnt_out) != v && guard < 5000) begin @(negedge clk); guard++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL R3 watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int p, h, f;
    // R1 reset state
    repeat (3) @(negedge clk);
    check_eq("R1 reset cnt_out", int'(cnt_out), 0);
    check_eq("R1 reset pwm_out", int'(pwm_out), 0);
    check_eq("R1 reset match_flag", int'(match_flag), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1 first cycle cnt_out", int'(cnt_out), 0);

    // R3 R5 single-slope, period register TOP, normal polarity
    setup(14, 2, 1, 24, 99);
    measure(p, h);
    check_eq("R3 fast per-reg period", p, 100);
    check_eq("R5 fast normal high", h, 25);
    count_flags(100, f);
    check_eq("R10 fast flags per period", f, 1);

    // R3 R5 fixed 8-bit TOP, inverted polarity
    setup(5, 3, 1, 64, 0);
    measure(p, h);
    check_eq("R3 fast 8-bit period", p, 256);
    check_eq("R5 fast inverted high", h, 191);

    // R6 spike with compare 0, 9-bit TOP
    setup(6, 2, 1, 0, 0);
    measure(p, h);
    check_eq("R6 spike period", p, 512);
    check_eq("R6 spike width", h, 1);

    // R6 compare equals TOP
    setup(14, 2, 1, 99, 99);
    repeat (120) @(negedge clk);
    count_high(300, h);
    check_eq("R6 const high normal", h, 300);
    setup(14, 3, 1, 99, 99);
    repeat (120) @(negedge clk);
    count_high(300, h);
    check_eq("R6 const low inverted", h, 0);

    // R8 toggle in code 15, undriven elsewhere
    setup(15, 1, 1, 9, 0);
    measure(p, h);
    check_eq("R8 toggle period", p, 20);
    check_eq("R8 toggle high", h, 10);
    setup(14, 1, 1, 24, 99);
    count_high(300, h);
    check_eq("R8 toggle ignored outside code 15", h, 0);

    // R4 R7 dual-slope with period register
    setup(10, 2, 1, 20, 49);
    measure(p, h);
    check_eq("R4 dual period", p, 98);
    check_eq("R7 dual normal high", h, 40);
    count_flags(98, f);
    check_eq("R10 dual flags per period", f, 2);
    setup(10, 3, 1, 20, 49);
    measure(p, h);
    check_eq("R7 dual inverted high", h, 58);

    // R4 R7 10-bit dual-slope inverted
    setup(3, 3, 1, 512, 0);
    measure(p, h);
    check_eq("R4 dual 10-bit period", p, 2046);
    check_eq("R7 dual 10-bit inverted high", h, 1022);

    // R2 prescale /8 in 8-bit dual-slope
    setup(1, 2, 2, 100, 0);
    measure(p, h);
    check_eq("R2 div8 dual period", p, 4080);
    check_eq("R2 div8 dual high", h, 1600);

    // R2 prescale /64
    setup(14, 2, 3, 4, 19);
    measure(p, h);
    check_eq("R2 div64 period", p, 1280);
    check_eq("R2 div64 high", h, 320);

    // R2 /256 and /1024 tick spacing, stopped select
    setup(14, 2, 4, 4, 19);
    step_gap(p);
    check_eq("R2 div256 step", p, 256);
    setup(14, 2, 5, 4, 19);
    step_gap(p);
    check_eq("R2 div1024 step", p, 1024);
    setup(14, 2, 0, 4, 19);
    repeat (2000) @(negedge clk);
    check_eq("R2 stopped count holds", int'(cnt_out), 0);

    // R11 minimum TOP
    setup(14, 2, 1, 1, 3);
    measure(p, h);
    check_eq("R11 fast min period", p, 4);
    check_eq("R11 fast min high", h, 2);
    setup(10, 2, 1, 1, 3);
    measure(p, h);
    check_eq("R11 dual min period", p, 6);
    check_eq("R11 dual min high", h, 2);

    // R9 double buffering of compare and period
    setup(14, 2, 1, 24, 99);
    measure(p, h);
    wait_cnt(5);
    wr(1, 60);
    wait_cnt(30);
    check_eq("R9 old compare still active", int'(pwm_out), 0);
    measure(p, h);
    check_eq("R9 new compare next period", h, 61);
    wait_cnt(5);
    wr(1, 24);
    wr(2, 49);
    wait_cnt(80);
    check_eq("R9 old period still active", int'(cnt_out), 80);
    measure(p, h);
    check_eq("R9 new period applied", p, 50);
    check_eq("R9 new compare with new period", h, 25);

    // R12 write to address 3 ignored
    setup(14, 2, 1, 24, 99);
    wr(3, 0);
    measure(p, h);
    check_eq("R12 addr3 period unchanged", p, 100);
    check_eq("R12 addr3 high unchanged", h, 25);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule